// File: doc/BRIEF.md
# Framed Serial Symbol Transceiver

This block sits between a host and the serial data pins of a short-range radio. On the receive side it passes the raw line through a synchronizer and recovers bit timing itself. A counter realigns on every line transition and strobes a sample in the middle of each bit period. The recovered bits feed a sliding 12-bit window that is compared against a fixed start pattern. When the window matches, a start flag latches. From then on every group of 12 recovered bits is delivered to the host as a symbol, together with a ready flag.

The start flag stays set until the host pulses a dedicated clear input. The clear input also empties the window, so the search begins again from scratch. On the transmit side the host writes a 12-bit symbol. The block sends it most significant bit first, holding each bit for a fixed number of system clock cycles, but only while transmit enable is high. With the default 40 cycles per bit, system clocks from 4 MHz to 40 MHz give line rates from 100 kbps to 1 Mbps.

Top module: `sym_xcvr`

## Requirements
- R1: After reset, start_det, data_rdy and overrun are 0 and tx_line is 0.
- R2: A tx_load pulse while tx_en is high sends tx_sym MSB first. The MSB appears in the cycle after the load edge. Each bit is held for OVS (default 40) cycles. After the 12th bit, tx_line returns to 0 and stays there until the next load.
- R3: While tx_en is low, tx_line is 0. If tx_en drops during a symbol, the bit position resets. When tx_en rises again, the same symbol restarts from its MSB, and that first bit is held until OVS clock edges after the rise.
- R4: start_det rises once the 12 most recently recovered bits equal START_PAT (default 12'hB38), with the earliest received bit in the MSB position. It is still 0 after only the first 11 pattern bits. Once set, it stays set until start_clr.
- R5: No symbol is assembled while start_det is 0: data_rdy cannot rise without a detected start.
- R6: After a start is detected, each following group of 12 recovered bits is presented on rx_sym, with the earliest bit in bit 11, and sets data_rdy. This includes a group that happens to equal START_PAT.
- R7: A one-cycle rd_ack pulse clears data_rdy and overrun.
- R8: If a symbol completes while data_rdy is still set and unacknowledged, overrun goes to 1 and rx_sym takes the newer symbol.
- R9: A start_clr pulse clears start_det and the search window. Bits arriving afterwards produce no symbol until START_PAT has been received again in full.
- R10: Bit timing is recovered from line transitions alone. The counter restarts at each transition and samples at count OVS/2, so two strobes are never adjacent. A line driven at an arbitrary phase relative to the clock is received correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, OVS cycles per serial bit |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_line | input | 1 | Raw serial data from the radio receiver |
| start_clr | input | 1 | Clears start detection and re-arms the search |
| rd_ack | input | 1 | Host acknowledges the current received symbol |
| start_det | output | 1 | Sticky flag: start pattern has been seen |
| rx_sym | output | 12 | Last complete received symbol |
| data_rdy | output | 1 | A received symbol is waiting to be read |
| overrun | output | 1 | A symbol was overwritten before acknowledgement |
| tx_en | input | 1 | Transmit enable; serial output is active only while high |
| tx_load | input | 1 | Load pulse for tx_sym |
| tx_sym | input | 12 | Symbol to transmit |
| tx_line | output | 1 | Serial data to the radio transmitter |

## Verification
The assertions check several properties on every cycle:
- start_det is sticky, and start_clr clears it.
- data_rdy never rises without a prior start.
- overrun only rises while a symbol is pending.
- rd_ack empties the holding state.
- tx_line is low whenever tx_en is low.
- the transmit bit position resets when tx_en drops.
- recovered strobes are never adjacent.

Other behaviour depends on whole bit sequences, and only the bench scenarios can show it:
- bit order and bit duration on the transmit side.
- the exact bit at which the start pattern is recognised.
- correct symbol values across a sweep sent through a transmit-to-receive loopback.
- overwrite of a pending symbol.
- re-arming after a clear.

// File: rtl/sx_pkg.sv
package sx_pkg;
  localparam int unsigned DEF_SYM_W = 12;
  localparam int unsigned DEF_OVS   = 40;
  localparam logic [11:0] DEF_START = 12'hB38;

  // Midpoint of a bit period, where the receiver samples.
  function automatic int unsigned mid_count(input int unsigned ovs);
    return ovs / 2;
  endfunction
endpackage

// File: rtl/sx_rx_timing.sv
module sx_rx_timing #(
  parameter int unsigned OVS = sx_pkg::DEF_OVS
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_in,
  output logic bit_stb,
  output logic bit_val
);
  localparam int unsigned CW  = $clog2(OVS);
  localparam int unsigned MID = sx_pkg::mid_count(OVS);

  logic [2:0]    sync_q;   // [0] first flop, [1] synchronized, [2] previous
  logic [CW-1:0] phase_q;
  logic          line_edge;

  assign line_edge = sync_q[1] ^ sync_q[2];
  assign bit_stb   = (phase_q == CW'(MID)) && !line_edge;
  assign bit_val   = sync_q[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= '0;
      phase_q <= '0;
    end else begin
      sync_q <= {sync_q[1:0], line_in};
      if (line_edge || phase_q == CW'(OVS - 1)) phase_q <= '0;
      else                                       phase_q <= phase_q + 1'b1;
    end
  end

  // R10: two sampling strobes are never adjacent
  p_stb_spaced_r10: assert property (@(posedge clk) disable iff (!rst_n)
    bit_stb |=> !bit_stb);
  // R10: a transition restarts the bit phase
  p_edge_realign_r10: assert property (@(posedge clk) disable iff (!rst_n)
    line_edge |=> (phase_q == '0));
endmodule

// File: rtl/sx_rx_framer.sv
module sx_rx_framer #(
  parameter int unsigned      SYM_W     = sx_pkg::DEF_SYM_W,
  parameter logic [SYM_W-1:0] START_PAT = sx_pkg::DEF_START
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_stb,
  input  logic             bit_val,
  input  logic             start_clr,
  input  logic             rd_ack,
  output logic             start_det,
  output logic [SYM_W-1:0] rx_sym,
  output logic             data_rdy,
  output logic             overrun
);
  localparam int unsigned BW = $clog2(SYM_W);

  logic [SYM_W-1:0] win_q, asm_q;
  logic [BW-1:0]    bcnt_q;
  logic [SYM_W-1:0] win_next, asm_next;
  logic             pat_hit, sym_done, assembling;

  function automatic logic [SYM_W-1:0] shift_in(input logic [SYM_W-1:0] v, input logic b);
    return {v[SYM_W-2:0], b};
  endfunction

  assign win_next   = shift_in(win_q, bit_val);
  assign asm_next   = shift_in(asm_q, bit_val);
  assign pat_hit    = bit_stb && !start_det && !start_clr && (win_next == START_PAT);
  assign assembling = bit_stb && start_det && !start_clr;
  assign sym_done   = assembling && (bcnt_q == BW'(SYM_W - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q     <= '0;
      asm_q     <= '0;
      bcnt_q    <= '0;
      start_det <= 1'b0;
      rx_sym    <= '0;
      data_rdy  <= 1'b0;
      overrun   <= 1'b0;
    end else begin
      if (start_clr)    win_q <= '0;
      else if (bit_stb) win_q <= win_next;

      if (start_clr) begin
        start_det <= 1'b0;
        bcnt_q    <= '0;
      end else if (pat_hit) begin
        start_det <= 1'b1;
        bcnt_q    <= '0;
      end else if (assembling) begin
        asm_q  <= asm_next;
        bcnt_q <= sym_done ? '0 : bcnt_q + 1'b1;
      end

      if (sym_done) rx_sym <= asm_next;

      if (sym_done)    data_rdy <= 1'b1;
      else if (rd_ack) data_rdy <= 1'b0;

      if (sym_done && data_rdy && !rd_ack) overrun <= 1'b1;
      else if (rd_ack)                     overrun <= 1'b0;
    end
  end

  // R4: start detection is sticky until cleared
  p_start_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (start_det && !start_clr) |=> start_det);
  // R9: clear drops the start flag
  p_start_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    start_clr |=> !start_det);
  // R5: a symbol is only announced after a start
  p_rdy_after_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_rdy) |-> $past(start_det));
  // R8: overrun only appears with a pending symbol
  p_ovr_pending_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> data_rdy);
  // R7: acknowledge empties ready and overrun
  p_ack_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ack && !sym_done) |=> (!data_rdy && !overrun));
endmodule

// File: rtl/sx_tx_serial.sv
module sx_tx_serial #(
  parameter int unsigned SYM_W = sx_pkg::DEF_SYM_W,
  parameter int unsigned OVS   = sx_pkg::DEF_OVS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_en,
  input  logic             tx_load,
  input  logic [SYM_W-1:0] tx_sym,
  output logic             tx_line
);
  localparam int unsigned CW = $clog2(OVS);
  localparam int unsigned IW = $clog2(SYM_W + 1);

  logic [SYM_W-1:0] sym_q;
  logic [IW-1:0]    idx_q;   // SYM_W means finished
  logic [CW-1:0]    cyc_q;
  logic             sending;

  function automatic logic msb_first(input logic [SYM_W-1:0] s, input logic [IW-1:0] i);
    return s[SYM_W - 1 - int'(i)];
  endfunction

  assign sending = tx_en && (idx_q < IW'(SYM_W));
  assign tx_line = sending ? msb_first(sym_q, idx_q) : 1'b0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sym_q <= '0;
      idx_q <= IW'(SYM_W);
      cyc_q <= '0;
    end else if (tx_load) begin
      sym_q <= tx_sym;
      idx_q <= '0;
      cyc_q <= '0;
    end else if (!tx_en) begin
      cyc_q <= '0;
      if (idx_q < IW'(SYM_W)) idx_q <= '0;
    end else if (sending) begin
      if (cyc_q == CW'(OVS - 1)) begin
        cyc_q <= '0;
        idx_q <= idx_q + 1'b1;
      end else begin
        cyc_q <= cyc_q + 1'b1;
      end
    end
  end

  // R3: output is idle whenever transmit is disabled
  p_idle_when_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !tx_en |-> !tx_line);
  // R3: disabling mid-symbol rewinds to the first bit
  p_rewind_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!tx_en && !tx_load && idx_q != IW'(SYM_W)) |=> (idx_q == '0));
endmodule

// File: rtl/sym_xcvr.sv
module sym_xcvr #(
  parameter int unsigned SYM_W     = sx_pkg::DEF_SYM_W,
  parameter int unsigned OVS       = sx_pkg::DEF_OVS,
  parameter logic [SYM_W-1:0] START_PAT = sx_pkg::DEF_START
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_line,
  input  logic             start_clr,
  input  logic             rd_ack,
  output logic             start_det,
  output logic [SYM_W-1:0] rx_sym,
  output logic             data_rdy,
  output logic             overrun,
  input  logic             tx_en,
  input  logic             tx_load,
  input  logic [SYM_W-1:0] tx_sym,
  output logic             tx_line
);
  logic bit_stb, bit_val;

  sx_rx_timing #(.OVS(OVS)) u_timing (
    .clk(clk), .rst_n(rst_n), .line_in(rx_line),
    .bit_stb(bit_stb), .bit_val(bit_val)
  );

  sx_rx_framer #(.SYM_W(SYM_W), .START_PAT(START_PAT)) u_framer (
    .clk(clk), .rst_n(rst_n), .bit_stb(bit_stb), .bit_val(bit_val),
    .start_clr(start_clr), .rd_ack(rd_ack), .start_det(start_det),
    .rx_sym(rx_sym), .data_rdy(data_rdy), .overrun(overrun)
  );

  sx_tx_serial #(.SYM_W(SYM_W), .OVS(OVS)) u_tx (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .tx_load(tx_load),
    .tx_sym(tx_sym), .tx_line(tx_line)
  );
endmodule

// File: tb/tb_sym_xcvr.sv
`timescale 1ns/1ps
module tb_sym_xcvr;
  localparam int W   = 12;
  localparam int OVS = 40;
  localparam logic [W-1:0] PAT = 12'hB38;
  localparam int NSYM = 48;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic drv = 1'b0, loop = 1'b0;
  logic start_clr = 1'b0, rd_ack = 1'b0, tx_en = 1'b0, tx_load = 1'b0;
  logic [W-1:0] tx_sym = '0;
  logic start_det, data_rdy, overrun, tx_line, rx_line;
  logic [W-1:0] rx_sym;

  int errors = 0, checks = 0, rx_idx = 0;
  logic mon_en = 1'b0;
  logic [W-1:0] exp_q [NSYM];

  always #2.5 clk = ~clk;
  assign rx_line = loop ? tx_line : drv;

  sym_xcvr dut (
    .clk(clk), .rst_n(rst_n), .rx_line(rx_line), .start_clr(start_clr),
    .rd_ack(rd_ack), .start_det(start_det), .rx_sym(rx_sym),
    .data_rdy(data_rdy), .overrun(overrun), .tx_en(tx_en),
    .tx_load(tx_load), .tx_sym(tx_sym), .tx_line(tx_line)
  );

  task automatic check(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  // Send one symbol from the transmitter; optionally check every bit mid-period.
  task automatic tx_send(input logic [W-1:0] v, input bit chk);
    tx_sym  = v;
    tx_load = 1'b1;
    @(negedge clk) tx_load = 1'b0;
    for (int i = 0; i < W; i++) begin
      repeat (OVS/2) @(negedge clk);
      if (chk) check("R2 tx bit", 32'(tx_line), 32'(v[W-1-i]));
      repeat (OVS/2 - ((i == W-1) ? 1 : 0)) @(negedge clk);
    end
  endtask

  task automatic drive_bits(input logic [W-1:0] v, input int n);
    for (int i = 0; i < n; i++) begin
      drv = v[W-1-i];
      repeat (OVS) @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < NSYM; i++) exp_q[i] = W'((i * 1237 + 'h5A) & 'hFFF);
    exp_q[5] = PAT;
    exp_q[6] = '0;
    exp_q[7] = '1;

    fork
      forever begin
        @(negedge clk);
        if (mon_en) begin
          if (data_rdy && !rd_ack) begin
            check("R6 loopback symbol", 32'(rx_sym), 32'(exp_q[rx_idx % NSYM]));
            rx_idx++;
            rd_ack = 1'b1;
          end else begin
            rd_ack = 1'b0;
          end
        end
      end
    join_none

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 start_det", 32'(start_det), 0);
    check("R1 data_rdy", 32'(data_rdy), 0);
    check("R1 overrun", 32'(overrun), 0);
    check("R1 tx_line", 32'(tx_line), 0);

    // R2: bit order, bit duration and idle after the symbol
    tx_en = 1'b1;
    tx_send(12'hA53, 1'b1);
    @(negedge clk) check("R2 idle after symbol", 32'(tx_line), 0);
    tx_send(12'h001, 1'b1);
    @(negedge clk) check("R2 idle after symbol", 32'(tx_line), 0);
    tx_send(12'h800, 1'b1);
    repeat (OVS) @(negedge clk);
    check("R2 stays idle", 32'(tx_line), 0);

    // R3: drop enable mid-symbol, then restart from MSB
    tx_sym = 12'hC3A;
    tx_load = 1'b1;
    @(negedge clk) tx_load = 1'b0;
    repeat (3*OVS + OVS/2) @(negedge clk);
    tx_en = 1'b0;
    @(negedge clk) check("R3 low when disabled", 32'(tx_line), 0);
    repeat (OVS) @(negedge clk);
    check("R3 still low when disabled", 32'(tx_line), 0);
    tx_en = 1'b1;
    repeat (OVS/2) @(negedge clk);
    check("R3 restart bit11", 32'(tx_line), 1);
    repeat (OVS) @(negedge clk);
    check("R3 restart bit10", 32'(tx_line), 1);
    repeat (OVS) @(negedge clk);
    check("R3 restart bit9", 32'(tx_line), 0);
    repeat (W*OVS) @(negedge clk);
    check("R3 idle after restart", 32'(tx_line), 0);

    // R5: nothing received yet
    check("R5 no symbol before start", 32'(data_rdy), 0);
    check("R4 no start yet", 32'(start_det), 0);

    // R6/R10: loopback sweep
    loop = 1'b1;
    mon_en = 1'b1;
    tx_send(PAT, 1'b0);
    for (int n = 0; n < NSYM; n++) tx_send(exp_q[n], 1'b0);
    @(negedge clk);
    repeat (2*OVS) @(negedge clk);
    check("R6 symbols received", 32'(rx_idx), NSYM);
    check("R4 start held through sweep", 32'(start_det), 1);
    check("R8 no overrun with prompt ack", 32'(overrun), 0);
    mon_en = 1'b0;
    rd_ack = 1'b0;
    loop = 1'b0;
    drv = 1'b0;
    repeat (OVS) @(negedge clk);

    // R9: clear re-arms, stray bits ignored
    start_clr = 1'b1;
    @(negedge clk) start_clr = 1'b0;
    check("R9 start cleared", 32'(start_det), 0);
    repeat (5) @(negedge clk);   // arbitrary phase for R10
    drive_bits(12'h0F0, 12);
    drive_bits(12'h000, 3);
    check("R9 no symbol after clear", 32'(data_rdy), 0);
    check("R9 start still clear", 32'(start_det), 0);

    // R4: detection only on the final pattern bit
    drive_bits(PAT, 11);
    check("R4 not yet on 11 bits", 32'(start_det), 0);
    drv = PAT[0];
    repeat (OVS) @(negedge clk);
    check("R4 start on 12th bit", 32'(start_det), 1);

    // R6/R8: two symbols without acknowledge
    drive_bits(12'h9A5, 12);
    check("R6 direct symbol", 32'(rx_sym), 32'h9A5);
    check("R6 ready", 32'(data_rdy), 1);
    check("R8 no overrun yet", 32'(overrun), 0);
    drive_bits(12'h36C, 12);
    drive_bits(12'h000, 2);
    check("R8 overrun set", 32'(overrun), 1);
    check("R8 newer symbol kept", 32'(rx_sym), 32'h36C);
    check("R8 still ready", 32'(data_rdy), 1);

    // R7: acknowledge clears both flags
    rd_ack = 1'b1;
    @(negedge clk) rd_ack = 1'b0;
    check("R7 ready cleared", 32'(data_rdy), 0);
    check("R7 overrun cleared", 32'(overrun), 0);
    check("R4 start still set", 32'(start_det), 1);

    finish_run();
  end
endmodule